// File: doc/BRIEF.md
# Age-Ordered Multi-Pool Issue Selector

This block holds ready instructions in one small pool per operation class and, every cycle, grants the oldest of them for issue. An instruction is identified by a tag and carries a sequence number. Smaller sequence numbers mean older instructions, and the comparison works across counter wrap-around. Each pool offers only its oldest entry. The heads of all pools whose functional unit is free are ranked by age. Up to `ISSUE_W` of them are granted, and each granted entry leaves its pool.

Insertion uses a valid/ready handshake per class. A producer holds `ins_valid` with stable payload until it sees `ins_ready` high at a rising edge. `ins_ready` falls when the pool is full, and during any cycle in which a squash is presented. The issue port has no back-pressure: each registered slot is valid for exactly one cycle per grant. A class whose unit is busy is skipped while it holds entries, and a saturating per-class counter records each skipped cycle. A squash removes every pooled entry younger than the given sequence number.

Top module: `issue_select`

## Requirements
- R1: After reset all issue slots are invalid, every busy counter reads zero and every `ins_ready` bit is high.
- R2: A class accepts an entry at a rising edge where its `ins_valid` and `ins_ready` are both high. `ins_ready` is low while that pool holds `POOL_DEPTH` entries or while `squash_valid` is high, and an offer made while it is low leaves the pool unchanged.
- R3: Within one class, entries are issued in age order, oldest first, and at most one entry per class is issued per cycle.
- R4: Across classes, the eligible pool heads are ranked by age and at most `ISSUE_W` are granted per cycle. Slot 0 holds the oldest grant, later slots hold successively younger ones, and valid slots are packed from slot 0. Equal sequence numbers rank the lower class index first.
- R5: An entry accepted at edge k can appear on the issue port no earlier than the output registered at edge k+1. Each grant shows on its slot for exactly one cycle.
- R6: Sequence number a is older than b when (a - b) modulo 2^SEQ_W has its top bit set, so 250 is older than 3 for an 8-bit sequence.
- R7: A class whose `unit_busy` bit is high in a cycle is not granted in that cycle, and its entries stay pooled.
- R8: A class's busy counter increments, saturating at 2^CNT_W - 1, at each edge where that class's pool is non-empty, its `unit_busy` bit is high and no squash is presented.
- R9: At an edge where `squash_valid` is high, every entry younger than `squash_seq` is removed, and entries equal to or older than it remain. No grant is made and no entry is inserted in that cycle.
- R10: Class c occupies bits [c*W +: W] of the flat per-class vectors, and slot s occupies bits [s*W +: W] of the flat issue vectors. `iss_class` carries the binary class index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | NUM_CLASS | Insert offer per class |
| ins_ready | output | NUM_CLASS | Insert acceptance per class |
| ins_seq | input | NUM_CLASS*SEQ_W | Sequence number of each offer |
| ins_tag | input | NUM_CLASS*TAG_W | Tag of each offer |
| unit_busy | input | NUM_CLASS | Functional unit of the class cannot take work this cycle |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| iss_valid | output | ISSUE_W | Issue slot holds a grant |
| iss_tag | output | ISSUE_W*TAG_W | Tag per issue slot |
| iss_class | output | ISSUE_W*CLS_W | Class index per issue slot |
| busy_count | output | NUM_CLASS*CNT_W | Saturating skipped-cycle counter per class |

## Verification
The bench builds the block with three classes, four-entry pools, an issue width of two, 8-bit sequence numbers and 4-bit busy counters. Because there are three classes but only two slots, a ready head can lose purely on age and wait a cycle. Four-entry pools fill in a few inserts, so the full-pool refusal is reached quickly. The 8-bit sequence makes a wrap-around pair easy to build, and the 4-bit counter reaches saturation within twenty busy cycles.

// File: rtl/isel_pkg.sv
package isel_pkg;

  // True when a is older than b under modulo-2^w ordering.
  function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b,
                                     input int unsigned w);
    logic [31:0] d;
    d = a - b;
    return ((d >> (w - 1)) & 32'd1) == 32'd1;
  endfunction

endpackage

// File: rtl/isel_pool.sv
module isel_pool #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             pop,
  input  logic             squash,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic             full,
  output logic             nonempty,
  output logic [SEQ_W-1:0] head_seq,
  output logic [TAG_W-1:0] head_tag
);
  import isel_pkg::*;

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q;
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [IDX_W-1:0] free_idx, head_idx;

  assign full     = &vld_q;
  assign nonempty = |vld_q;

  // lowest empty slot takes the next insert
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

  // oldest valid entry is the head
  always_comb begin
    logic found;
    found    = 1'b0;
    head_idx = '0;
    head_seq = '0;
    head_tag = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && (!found || seq_older(32'(seq_q[i]), 32'(head_seq), SEQ_W))) begin
        found    = 1'b1;
        head_idx = IDX_W'(i);
        head_seq = seq_q[i];
        head_tag = tag_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (squash && vld_q[i] && seq_older(32'(squash_seq), 32'(seq_q[i]), SEQ_W))
          vld_q[i] <= 1'b0;
      end
      if (pop)  vld_q[head_idx] <= 1'b0;
      if (push) vld_q[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      seq_q[free_idx] <= push_seq;
      tag_q[free_idx] <= push_tag;
    end
  end

  AST_POOL_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !squash) |=> $countones(vld_q) == $past($countones(vld_q)) + 1); // R2

  AST_POOL_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !squash) |=> $countones(vld_q) == $past($countones(vld_q)) - 1); // R3

  for (genvar g = 0; g < DEPTH; g++) begin : g_purge
    AST_SQUASH_PURGE: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> !(vld_q[g] && seq_older(32'(seq_q[g]), 32'($past(squash_seq)), SEQ_W) == 1'b0
                   && seq_q[g] != $past(squash_seq))); // R9
  end

endmodule

// File: rtl/isel_arbiter.sv
module isel_arbiter #(
  parameter int NUM_CLASS = 3,
  parameter int ISSUE_W   = 2,
  parameter int SEQ_W     = 8,
  parameter int CLS_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CLASS-1:0]       elig,
  input  logic [NUM_CLASS*SEQ_W-1:0] head_seq,
  output logic [NUM_CLASS-1:0]       grant,
  output logic [ISSUE_W-1:0]         slot_vld,
  output logic [ISSUE_W*CLS_W-1:0]   slot_cls
);
  import isel_pkg::*;

  localparam int RANK_W = $clog2(NUM_CLASS + 1);

  logic [RANK_W-1:0] rank [NUM_CLASS];

  // rank = number of eligible heads that beat this one on age
  always_comb begin
    for (int c = 0; c < NUM_CLASS; c++) begin
      rank[c] = '0;
      for (int d = 0; d < NUM_CLASS; d++) begin
        if (d != c && elig[d]) begin
          if (seq_older(32'(head_seq[d*SEQ_W +: SEQ_W]), 32'(head_seq[c*SEQ_W +: SEQ_W]), SEQ_W) ||
              (head_seq[d*SEQ_W +: SEQ_W] == head_seq[c*SEQ_W +: SEQ_W] && d < c))
            rank[c] = rank[c] + RANK_W'(1);
        end
      end
    end
  end

  always_comb begin
    slot_vld = '0;
    slot_cls = '0;
    for (int c = 0; c < NUM_CLASS; c++) begin
      grant[c] = elig[c] && (32'(rank[c]) < ISSUE_W);
      for (int s = 0; s < ISSUE_W; s++) begin
        if (grant[c] && 32'(rank[c]) == s) begin
          slot_vld[s] = 1'b1;
          slot_cls[s*CLS_W +: CLS_W] = CLS_W'(c);
        end
      end
    end
  end

  AST_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= ISSUE_W); // R4

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~elig) == '0); // R7

endmodule

// File: rtl/isel_busy_ctr.sv
module isel_busy_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (inc && count != TOP)  count <= count + CNT_W'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count != TOP) |=> count == $past(count) + CNT_W'(1)); // R8

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc || count == TOP) |=> $stable(count)); // R8

endmodule

// File: rtl/issue_select.sv
module issue_select #(
  parameter int NUM_CLASS  = 3,
  parameter int POOL_DEPTH = 4,
  parameter int ISSUE_W    = 2,
  parameter int SEQ_W      = 8,
  parameter int TAG_W      = 8,
  parameter int CNT_W      = 8,
  localparam int CLS_W     = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CLASS-1:0]       ins_valid,
  output logic [NUM_CLASS-1:0]       ins_ready,
  input  logic [NUM_CLASS*SEQ_W-1:0] ins_seq,
  input  logic [NUM_CLASS*TAG_W-1:0] ins_tag,
  input  logic [NUM_CLASS-1:0]       unit_busy,
  input  logic                       squash_valid,
  input  logic [SEQ_W-1:0]           squash_seq,
  output logic [ISSUE_W-1:0]         iss_valid,
  output logic [ISSUE_W*TAG_W-1:0]   iss_tag,
  output logic [ISSUE_W*CLS_W-1:0]   iss_class,
  output logic [NUM_CLASS*CNT_W-1:0] busy_count
);

  logic [NUM_CLASS-1:0]       full, nonempty, elig, grant, push, skip;
  logic [NUM_CLASS*SEQ_W-1:0] head_seq;
  logic [NUM_CLASS*TAG_W-1:0] head_tag;
  logic [ISSUE_W-1:0]         slot_vld;
  logic [ISSUE_W*CLS_W-1:0]   slot_cls;
  logic [ISSUE_W*TAG_W-1:0]   slot_tag;

  assign ins_ready = ~full & {NUM_CLASS{~squash_valid}};
  assign push      = ins_valid & ins_ready;
  assign elig      = nonempty & ~unit_busy & {NUM_CLASS{~squash_valid}};
  assign skip      = nonempty & unit_busy & {NUM_CLASS{~squash_valid}};

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
    isel_pool #(.DEPTH(POOL_DEPTH), .SEQ_W(SEQ_W), .TAG_W(TAG_W)) u_pool (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push[c]),
      .push_seq   (ins_seq[c*SEQ_W +: SEQ_W]),
      .push_tag   (ins_tag[c*TAG_W +: TAG_W]),
      .pop        (grant[c]),
      .squash     (squash_valid),
      .squash_seq (squash_seq),
      .full       (full[c]),
      .nonempty   (nonempty[c]),
      .head_seq   (head_seq[c*SEQ_W +: SEQ_W]),
      .head_tag   (head_tag[c*TAG_W +: TAG_W])
    );

    isel_busy_ctr #(.CNT_W(CNT_W)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (skip[c]),
      .count (busy_count[c*CNT_W +: CNT_W])
    );
  end

  isel_arbiter #(
    .NUM_CLASS (NUM_CLASS),
    .ISSUE_W   (ISSUE_W),
    .SEQ_W     (SEQ_W),
    .CLS_W     (CLS_W)
  ) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig     (elig),
    .head_seq (head_seq),
    .grant    (grant),
    .slot_vld (slot_vld),
    .slot_cls (slot_cls)
  );

  // route the winning head tag into each slot
  always_comb begin
    slot_tag = '0;
    for (int s = 0; s < ISSUE_W; s++) begin
      for (int c = 0; c < NUM_CLASS; c++) begin
        if (slot_vld[s] && slot_cls[s*CLS_W +: CLS_W] == CLS_W'(c))
          slot_tag[s*TAG_W +: TAG_W] = head_tag[c*TAG_W +: TAG_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid <= '0;
      iss_tag   <= '0;
      iss_class <= '0;
    end else begin
      iss_valid <= slot_vld;
      iss_tag   <= slot_tag;
      iss_class <= slot_cls;
    end
  end

  AST_SQUASH_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> iss_valid == '0); // R9

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot_chk
    AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[s] |-> ((($past(unit_busy) >> iss_class[s*CLS_W +: CLS_W]) & NUM_CLASS'(1)) == '0)); // R7
    if (s > 0) begin : g_pack
      AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[s] |-> iss_valid[s-1]); // R4
    end
  end

endmodule

// File: tb/issue_select_bench.sv
module issue_select_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3, DEP = 4, IW = 2, SW = 8, TW = 8, CW = 4, KW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0]    ins_valid, ins_ready, unit_busy;
  logic [NC*SW-1:0] ins_seq;
  logic [NC*TW-1:0] ins_tag;
  logic             squash_valid;
  logic [SW-1:0]    squash_seq;
  logic [IW-1:0]    iss_valid;
  logic [IW*TW-1:0] iss_tag;
  logic [IW*KW-1:0] iss_class;
  logic [NC*CW-1:0] busy_count;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_select #(.NUM_CLASS(NC), .POOL_DEPTH(DEP), .ISSUE_W(IW), .SEQ_W(SW),
                 .TAG_W(TW), .CNT_W(CW)) u_issue_select (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_seq(ins_seq), .ins_tag(ins_tag), .unit_busy(unit_busy),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .iss_valid(iss_valid),
    .iss_tag(iss_tag), .iss_class(iss_class), .busy_count(busy_count));

  function automatic logic [TW-1:0] tag_of(input logic [SW-1:0] s);
    return s ^ 8'hA5;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_slot(input string req, input int s, input bit v,
                          input int cls, input logic [SW-1:0] seq);
    chk({req, " valid"}, int'(iss_valid[s]), int'(v));
    if (v) begin
      chk({req, " class"}, int'(iss_class[s*KW +: KW]), cls);
      chk({req, " tag"}, int'(iss_tag[s*TW +: TW]), int'(tag_of(seq)));
    end
  endtask

  task automatic put(input int c, input logic [SW-1:0] s);
    ins_valid[c] = 1'b1;
    ins_seq[c*SW +: SW] = s;
    ins_tag[c*TW +: TW] = tag_of(s);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; ins_valid = '0; ins_seq = '0; ins_tag = '0;
    unit_busy = '0; squash_valid = 1'b0; squash_seq = '0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    apply_reset();
    chk("R1 iss_valid", int'(iss_valid), 0);
    chk("R1 busy_count", int'(busy_count), 0);
    chk("R1 ins_ready", int'(ins_ready), 7);
  endtask

  task automatic t_order();
    apply_reset();
    unit_busy = '1;
    put(0, 10); put(1, 5); put(2, 7); step();
    ins_valid = '0; put(0, 3); put(1, 20); step();
    ins_valid = '0; unit_busy = '0; step();
    chk_slot("R4 r3_ pass1 s0", 0, 1, 0, 3);
    chk_slot("R4 pass1 s1", 1, 1, 1, 5);
    step();
    chk_slot("R4 pass2 s0", 0, 1, 2, 7);
    chk_slot("R3 pass2 s1", 1, 1, 0, 10);
    step();
    chk_slot("R3 pass3 s0", 0, 1, 1, 20);
    chk_slot("R4 pass3 s1", 1, 0, 0, 0);
    step();
    chk("R5 drained", int'(iss_valid), 0);
  endtask

  task automatic t_latency();
    apply_reset();
    put(2, 50); step();
    ins_valid = '0;
    chk("R5 not before k+1", int'(iss_valid), 0);
    step();
    chk_slot("R5 at k+1", 0, 1, 2, 50);
    step();
    chk("R5 one cycle", int'(iss_valid), 0);
  endtask

  task automatic t_full();
    apply_reset();
    unit_busy = '1;
    for (int i = 0; i < DEP; i++) begin
      put(0, SW'(40 + i)); step();
    end
    ins_valid = '0; #1;
    chk("R2 full ready low", int'(ins_ready[0]), 0);
    chk("R2 other ready", int'(ins_ready[1]), 1);
    put(0, 1); step();
    ins_valid = '0; unit_busy = '0; step();
    chk_slot("R2 ignored offer", 0, 1, 0, 40);
    chk("R3 one per class", int'(iss_valid[1]), 0);
    #1 chk("R2 ready again", int'(ins_ready[0]), 1);
    for (int i = 1; i < DEP; i++) begin
      step(); chk_slot("R3 drain", 0, 1, 0, SW'(40 + i));
    end
    step(); chk("R2 nothing extra", int'(iss_valid), 0);
  endtask

  task automatic t_busy();
    apply_reset();
    unit_busy = 3'b010;
    put(0, 9); put(1, 4); step();
    ins_valid = '0; step();
    chk_slot("R7 free class", 0, 1, 0, 9);
    chk_slot("R7 busy skipped", 1, 0, 0, 0);
    repeat (4) step();
    chk("R8 count c1", int'(busy_count[1*CW +: CW]), 5);
    chk("R8 count c0", int'(busy_count[0*CW +: CW]), 0);
    unit_busy = '0; step();
    chk_slot("R7 entry kept", 0, 1, 1, 4);
    chk("R8 count held", int'(busy_count[1*CW +: CW]), 5);
    apply_reset();
    unit_busy = 3'b001;
    put(0, 2); step();
    ins_valid = '0;
    repeat (20) step();
    chk("R8 saturate", int'(busy_count[0*CW +: CW]), 15);
  endtask

  task automatic t_tie_wrap();
    apply_reset();
    unit_busy = '1;
    put(0, 6); put(2, 6); put(1, 8); step();
    ins_valid = '0; unit_busy = '0; step();
    chk_slot("R4 tie s0", 0, 1, 0, 6);
    chk_slot("R10 tie s1", 1, 1, 2, 6);
    step();
    chk_slot("R4 after tie", 0, 1, 1, 8);
    apply_reset();
    unit_busy = '1;
    put(0, 3); put(1, 250); step();
    ins_valid = '0; unit_busy = '0; step();
    chk_slot("R6 wrap s0", 0, 1, 1, 250);
    chk_slot("R6 wrap s1", 1, 1, 0, 3);
  endtask

  task automatic t_squash();
    apply_reset();
    unit_busy = '1;
    put(0, 10); put(1, 20); put(2, 40); step();
    ins_valid = '0; put(0, 30); step();
    ins_valid = '0; unit_busy = '0;
    squash_valid = 1'b1; squash_seq = 20; put(2, 15); #1;
    chk("R9 ready low", int'(ins_ready), 0);
    step();
    squash_valid = 1'b0; ins_valid = '0;
    chk("R9 no grant", int'(iss_valid), 0);
    step();
    chk_slot("R9 kept s0", 0, 1, 0, 10);
    chk_slot("R9 equal kept", 1, 1, 1, 20);
    step();
    chk("R9 younger gone", int'(iss_valid), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_order();
    t_latency();
    t_full();
    t_busy();
    t_tie_wrap();
    t_squash();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule